// File: doc/BRIEF.md
# DE-Only Sync Regenerator

Some video sources deliver only a data-enable strobe and pixel data, with no horizontal or vertical sync pulses. Downstream logic still needs line and frame boundaries to order pixels correctly. This block rebuilds both syncs from the one thing such a source does carry: runs of consecutive pixels with data enable low.

A run of idle pixels that reaches a programmable horizontal threshold marks a line boundary. A longer run that reaches a second threshold, also counted in pixels, marks a frame boundary. The block emits active-high, single-pixel sync pulses and delays DE and pixel data by one clock so that all outputs stay aligned.

An external select input turns regeneration on only for sources that lack real syncs. When regeneration is off, or when the thresholds are illegal, the incoming syncs pass through with the same one-clock delay.

Top module: `de_sync_regen`

## Requirements
- R1: While reset is asserted, deOut, hsOut, vsOut, dataOut and cfgErr are all 0, whatever the inputs are.
- R2: With regeneration active, hsOut is 1 for exactly the clock after the input pixel whose DE-low run, counting that pixel, equals hGap.
- R3: With regeneration active, vsOut is 1 for exactly the clock after the input pixel whose DE-low run, counting that pixel, equals vGap.
- R4: Each regenerated sync fires at most once per DE-low run and re-arms only after a pixel with DE high.
- R5: The idle-pixel counter saturates at 2^CNT_W-1 instead of wrapping. A DE-low run far longer than that range produces no extra sync pulses.
- R6: cfgErr is 1 one clock after a cycle in which hGap < 2 or hGap >= vGap, and 0 one clock after any other cycle.
- R7: When regenEn is 0 or the configuration is illegal (R6), hsOut and vsOut equal hsIn and vsIn delayed by one clock.
- R8: deOut and dataOut equal deIn and dataIn delayed by one clock, in every mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regenEn | input | 1 | 1 selects sync regeneration, 0 selects pass-through |
| deIn | input | 1 | Incoming data enable, active high |
| hsIn | input | 1 | Incoming horizontal sync (used in pass-through) |
| vsIn | input | 1 | Incoming vertical sync (used in pass-through) |
| dataIn | input | DATA_W | Incoming pixel data |
| hGap | input | CNT_W | Idle-pixel count that triggers a horizontal sync |
| vGap | input | CNT_W | Idle-pixel count that triggers a vertical sync |
| deOut | output | 1 | Data enable, delayed one clock |
| hsOut | output | 1 | Horizontal sync out, active high |
| vsOut | output | 1 | Vertical sync out, active high |
| dataOut | output | DATA_W | Pixel data, delayed one clock |
| cfgErr | output | 1 | Illegal threshold configuration flag |

## Verification
The bench sweeps every threshold pair in a small range, legal and illegal, with regeneration both on and off. Under each pair it drives idle runs from zero up to past the vertical threshold. A comparator that is off by one would shift the sync by a pixel. A missing re-arm would drop the pulse on the following run, and a level-style compare would stretch the pulse over the rest of the run. A long idle run, more than twice the counter range, shows whether the counter wraps: a wrapping counter would fire a second pulse late in the run. Illegal pairs at the boundaries hGap = 1, hGap = vGap and hGap = 0 confirm that the error flag is raised and that the real syncs are forwarded rather than regenerated pulses.

// File: rtl/desync_pkg.sv
`timescale 1ns/1ps
package desync_pkg;
  // strobes handed from control to datapath each pixel
  typedef struct packed {
    logic hFire;
    logic vFire;
    logic useRegen;
  } syncStrobes_t;
endpackage

// File: rtl/desync_ctrl.sv
`timescale 1ns/1ps
module desync_ctrl
  import desync_pkg::*;
#(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             regenEn,
  input  logic             deIn,
  input  logic [CNT_W-1:0] hGap,
  input  logic [CNT_W-1:0] vGap,
  output syncStrobes_t     strobes,
  output logic             cfgBad
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] MIN_GAP = CNT_W'(2);

  // number of DE-low pixels seen before the current one
  logic [CNT_W-1:0] idleCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 idleCnt <= '0;
    else if (deIn)             idleCnt <= '0;
    else if (idleCnt != CNT_MAX) idleCnt <= idleCnt + 1'b1;
  end

  always_comb begin
    cfgBad           = (hGap < MIN_GAP) || (hGap >= vGap);
    strobes.useRegen = regenEn && !cfgBad;
    // equality against the run length fires once; saturation prevents refire
    strobes.hFire    = !deIn && (idleCnt == hGap - 1'b1);
    strobes.vFire    = !deIn && (idleCnt == vGap - 1'b1);
  end
endmodule

// File: rtl/desync_dp.sv
`timescale 1ns/1ps
module desync_dp
  import desync_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  syncStrobes_t      strobes,
  input  logic              cfgBad,
  input  logic              deIn,
  input  logic              hsIn,
  input  logic              vsIn,
  input  logic [DATA_W-1:0] dataIn,
  output logic              deOut,
  output logic              hsOut,
  output logic              vsOut,
  output logic [DATA_W-1:0] dataOut,
  output logic              cfgErr
);
  logic hsNext, vsNext;

  always_comb begin
    hsNext = strobes.useRegen ? strobes.hFire : hsIn;
    vsNext = strobes.useRegen ? strobes.vFire : vsIn;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      deOut   <= 1'b0;
      hsOut   <= 1'b0;
      vsOut   <= 1'b0;
      dataOut <= '0;
      cfgErr  <= 1'b0;
    end else begin
      deOut   <= deIn;
      hsOut   <= hsNext;
      vsOut   <= vsNext;
      dataOut <= dataIn;
      cfgErr  <= cfgBad;
    end
  end
endmodule

// File: rtl/de_sync_regen.sv
`timescale 1ns/1ps
module de_sync_regen
  import desync_pkg::*;
#(
  parameter int CNT_W  = 12,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regenEn,
  input  logic              deIn,
  input  logic              hsIn,
  input  logic              vsIn,
  input  logic [DATA_W-1:0] dataIn,
  input  logic [CNT_W-1:0]  hGap,
  input  logic [CNT_W-1:0]  vGap,
  output logic              deOut,
  output logic              hsOut,
  output logic              vsOut,
  output logic [DATA_W-1:0] dataOut,
  output logic              cfgErr
);
  syncStrobes_t strobes;
  logic         cfgBad;

  desync_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .regenEn(regenEn), .deIn(deIn),
    .hGap(hGap), .vGap(vGap), .strobes(strobes), .cfgBad(cfgBad)
  );

  desync_dp #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .cfgBad(cfgBad),
    .deIn(deIn), .hsIn(hsIn), .vsIn(vsIn), .dataIn(dataIn),
    .deOut(deOut), .hsOut(hsOut), .vsOut(vsOut), .dataOut(dataOut),
    .cfgErr(cfgErr)
  );
endmodule

// File: rtl/desync_checker.sv
`timescale 1ns/1ps
module desync_checker #(
  parameter int CNT_W  = 12,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              regenEn,
  input logic              deIn,
  input logic              hsIn,
  input logic              vsIn,
  input logic [DATA_W-1:0] dataIn,
  input logic [CNT_W-1:0]  hGap,
  input logic [CNT_W-1:0]  vGap,
  input logic              deOut,
  input logic              hsOut,
  input logic              vsOut,
  input logic [DATA_W-1:0] dataOut,
  input logic              cfgErr
);
  localparam logic [CNT_W-1:0] MIN_GAP = CNT_W'(2);
  logic pastValid;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pastValid <= 1'b0;
    else       pastValid <= 1'b1;
  end

  a_r8_de_delay: assert property (@(posedge clk) disable iff (!rstN)
    pastValid |-> deOut == $past(deIn));

  a_r8_data_delay: assert property (@(posedge clk) disable iff (!rstN)
    pastValid |-> dataOut == $past(dataIn));

  a_r2_hs_after_idle: assert property (@(posedge clk) disable iff (!rstN)
    (pastValid && hsOut && !cfgErr && $past(regenEn)) |-> !$past(deIn));

  a_r3_vs_after_idle: assert property (@(posedge clk) disable iff (!rstN)
    (pastValid && vsOut && !cfgErr && $past(regenEn)) |-> !$past(deIn));

  a_r6_cfg_flag: assert property (@(posedge clk) disable iff (!rstN)
    pastValid |-> cfgErr == (($past(hGap) < MIN_GAP) || ($past(hGap) >= $past(vGap))));

  a_r7_pass_through: assert property (@(posedge clk) disable iff (!rstN)
    (pastValid && (cfgErr || !$past(regenEn))) |->
      (hsOut == $past(hsIn) && vsOut == $past(vsIn)));
endmodule

bind de_sync_regen desync_checker #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/de_sync_regen_bench.sv
`timescale 1ns/1ps
module de_sync_regen_bench;
  localparam int CNT_W  = 12;
  localparam int DATA_W = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regenEn = 1'b0, deIn = 1'b0, hsIn = 1'b0, vsIn = 1'b0;
  logic [DATA_W-1:0] dataIn = '0;
  logic [CNT_W-1:0]  hGap = '0, vGap = '0;
  logic deOut, hsOut, vsOut, cfgErr;
  logic [DATA_W-1:0] dataOut;

  de_sync_regen #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_de_sync_regen (.*);

  always #2.5 clk = ~clk;

  int checks = 0, errors = 0;
  int nxtH = 0, nxtV = 0;
  logic nxtRegen = 1'b0;
  int lowRun = 0, cyc = 0, obsHs = 0, obsVs = 0;
  logic haveExp = 1'b0;
  logic expDe, expHs, expVs, expErr;
  logic [DATA_W-1:0] expData;

  task automatic chk(input logic ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", what, act, exp, cyc);
    end
  endtask

  task automatic setCfg(input int h, input int v, input logic r);
    nxtH = h; nxtV = v; nxtRegen = r;
  endtask

  // drives one pixel; first checks outputs produced by the previous pixel
  task automatic step(input logic de);
    logic err, hs, vs;
    logic [DATA_W-1:0] d;
    @(negedge clk);
    if (haveExp) begin
      if (hsOut) obsHs++;
      if (vsOut) obsVs++;
      chk(hsOut == expHs, "R2/R4/R7 hsOut", int'(hsOut), int'(expHs));
      chk(vsOut == expVs, "R3/R4/R7 vsOut", int'(vsOut), int'(expVs));
      chk(deOut == expDe, "R8 deOut", int'(deOut), int'(expDe));
      chk(dataOut == expData, "R8 dataOut", int'(dataOut), int'(expData));
      chk(cfgErr == expErr, "R6 cfgErr", int'(cfgErr), int'(expErr));
    end
    cyc++;
    hs = cyc[1];
    vs = cyc[2];
    d  = DATA_W'(cyc * 7);
    if (de) lowRun = 0; else lowRun++;
    err     = (nxtH < 2) || (nxtH >= nxtV);
    expErr  = err;
    expDe   = de;
    expData = d;
    expHs   = (nxtRegen && !err) ? (!de && lowRun == nxtH) : hs;
    expVs   = (nxtRegen && !err) ? (!de && lowRun == nxtV) : vs;
    deIn = de; hsIn = hs; vsIn = vs; dataIn = d;
    hGap = CNT_W'(nxtH); vGap = CNT_W'(nxtV); regenEn = nxtRegen;
    haveExp = 1'b1;
  endtask

  initial begin
    #(5.0 * 200000);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    // R1: reset holds every output low even with active inputs
    deIn = 1'b1; hsIn = 1'b1; vsIn = 1'b1; dataIn = '1; regenEn = 1'b1;
    repeat (3) @(negedge clk);
    chk({deOut, hsOut, vsOut, cfgErr} == 4'b0, "R1 flags in reset",
        int'({deOut, hsOut, vsOut, cfgErr}), 0);
    chk(dataOut == '0, "R1 dataOut in reset", int'(dataOut), 0);
    deIn = 1'b0; hsIn = 1'b0; vsIn = 1'b0; dataIn = '0;
    @(negedge clk);
    rstN = 1'b1;

    // sweep: all threshold pairs, both modes, idle runs 0..9
    // covers R2, R3, R4 (single fire, re-arm), R6 and R7 boundaries
    for (int r = 0; r < 2; r++) begin
      for (int h = 0; h < 6; h++) begin
        for (int v = 0; v < 8; v++) begin
          setCfg(h, v, r[0]);
          for (int len = 0; len < 10; len++) begin
            for (int k = 0; k < 1 + (len % 2); k++) step(1'b1);
            for (int k = 0; k < len; k++) step(1'b0);
          end
        end
      end
    end

    // R5: saturation, run longer than twice the counter range
    setCfg((1 << CNT_W) - 2, (1 << CNT_W) - 1, 1'b1);
    step(1'b1);
    step(1'b0);
    obsHs = 0; obsVs = 0;
    for (int k = 0; k < 2 * (1 << CNT_W) + 500; k++) step(1'b0);
    step(1'b1);
    chk(obsHs == 1, "R5 hs pulses in long run", obsHs, 1);
    chk(obsVs == 1, "R5 vs pulses in long run", obsVs, 1);

    step(1'b1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule